// File: doc/BRIEF.md
# BCD calendar clock counter

This block holds the current time and date as packed BCD fields: tenths of a second, seconds, minutes, hours, day of week, day of month, month and a two-digit year. A single-cycle enable pulse at 10 Hz drives it forward. Each pulse moves the tenths digit, and carries ripple up through the whole field chain in the same clock cycle. The carries stop at each month's true last day, and February takes leap years into account.

Software sets the time through a byte-wide write port with a 3-bit field select. The hours byte also carries the format selection. Bit 7 of the hours byte picks 12-hour counting with an AM/PM flag in bit 5. When bit 7 is clear, the hours count from 00 to 23. The format can be changed at any time by rewriting the hours byte.

Coming out of reset models the recovery from a complete loss of power. In that state a halt flag is raised, and the counters ignore the tick until software writes at least one byte.

Top module: `bcd_cal_clock`

## Requirements
- R1: After reset the fields read tenths 0, seconds 00, minutes 00, hours 00 in 24-hour format, day of week 0, date 01, month 01 and year 00, and `halted_o` is 1.
- R2: While `halted_o` is 1 and no write occurs, ticks change no field and the flag stays set.
- R3: Any write, whatever its field select (0 to 7), clears `halted_o` and sets tenths to 0 on the next clock. No tick is counted in a cycle that also carries a write.
- R4: Tenths count from 0 to 9 on each accepted tick. The tick that moves tenths from 9 to 0 also advances the seconds.
- R5: Seconds and minutes count in BCD from 00 to 59. Each passes a carry to the next field when it wraps from 59 to 00. With no tick and no write, no field changes.
- R6: In 24-hour format (hours bit 7 = 0) the hours run from 00 to 23 in bits 5:0. The step from 23 to 00 advances the date.
- R7: In 12-hour format (hours bit 7 = 1) the hours run 12, 01, …, 11 in bits 4:0, with bit 5 set for PM. Bit 5 toggles on the step from 11 to 12. The step from 11 PM to 12 AM advances the date. Bit 7 changes only on a write to the hours byte.
- R8: The date rolls to 01 and the month advances after day 30 in April, June, September and November. In the other months except February it rolls after day 31.
- R9: February rolls after day 29 when the year value is divisible by 4, with 00 counted as divisible. In all other years it rolls after day 28.
- R10: After 31 December the date becomes 01 January and the year advances in BCD. Year 99 wraps to 00.
- R11: The day of week counts from 0 to 6 and wraps to 0. It advances in the same cycle as the date and at no other time, apart from writes.
- R12: Field select codes are 0 seconds (bits 6:0), 1 minutes (bits 6:0), 2 hours, 3 day of week (bits 2:0), 4 date (bits 5:0), 5 month (bits 4:0), 6 year (bits 7:0) and 7 no field. A write loads only the selected field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (total power loss) |
| tick_i | input | 1 | One-cycle 10 Hz advance enable |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field select for the write |
| wr_data_i | input | 8 | Write data byte |
| tenths_o | output | 4 | Tenths of a second, 0 to 9 |
| sec_o | output | 7 | Seconds, BCD |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 8 | Hours byte: bit 7 format, bit 5 PM, BCD hour |
| dow_o | output | 3 | Day of week, 0 to 6 |
| date_o | output | 6 | Day of month, BCD |
| month_o | output | 5 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| halted_o | output | 1 | Counting blocked until first write |

## Verification
The bench loads times just short of a boundary and sends ten ticks, so that a single tenths carry must ripple through every field up to the one under test. It checks the 30-day and 31-day months and February in years 23, 24, 00, 10 and 12. A wrong leap rule would give 29 February in year 10, or skip it in year 00. It drives a write and a tick in the same cycle and writes with select 7; a design that lets ticks through while halted, or that counts on a write cycle, shows a tenths value other than the expected one. In 12-hour format it steps through 11 AM, 12 PM and 11 PM. A misplaced AM/PM toggle, or a date carry at noon instead of midnight, shows up directly in the hours byte and the date.

// File: rtl/bcd_cal_pkg.sv
// Package: shared field codes and BCD helpers for the calendar counter.
// Assumes all BCD inputs hold valid digits (0-9 per nibble).
package bcd_cal_pkg;

    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DOW   = 3'd3,
        FLD_DATE  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6,
        FLD_NONE  = 3'd7
    } fld_e;

    // Add one to a two-digit BCD value (no wrap at 99 handled here).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Convert a two-digit BCD value to binary.
    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        logic [6:0] tens;
        tens = {3'b000, v[7:4]};
        return (tens << 3) + (tens << 1) + {3'b000, v[3:0]};
    endfunction

    // A year is a leap year when its two-digit value is a multiple of 4.
    function automatic logic is_leap(input logic [7:0] yr);
        logic [6:0] b;
        b = bcd_to_bin(yr);
        return (b[1:0] == 2'b00);
    endfunction

    // Last day (BCD) of a month given in BCD.
    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_cal_wrap.sv
// Module: generic BCD wrap counter used for tenths, seconds, minutes,
// day of week and year. Counts FIRST..LAST in BCD on step_i, and flags
// wrap_o combinationally in the cycle it steps from LAST back to FIRST.
// Assumes WIDTH <= 8 and that FIRST/LAST are valid BCD values.
module bcd_cal_wrap #(
    parameter int         WIDTH = 7,
    parameter logic [7:0] FIRST = 8'h00,
    parameter logic [7:0] LAST  = 8'h59
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic             step_i,
    output logic [WIDTH-1:0] val_o,
    output logic             wrap_o
);
    import bcd_cal_pkg::*;

    localparam logic [WIDTH-1:0] RST_VAL = FIRST[WIDTH-1:0];

    logic [WIDTH-1:0] val_q;
    logic [WIDTH-1:0] val_d;
    logic [7:0]       ext;
    logic [7:0]       inc;
    logic             at_last;

    // Widen the stored value to a full BCD byte and compute its successor.
    always_comb begin
        ext              = '0;
        ext[WIDTH-1:0]   = val_q;
        inc              = bcd_inc(ext);
        at_last          = (ext >= LAST);
    end

    // Select load, step-with-wrap, or hold.
    always_comb begin
        val_d = val_q;
        if (load_i)
            val_d = load_val_i;
        else if (step_i)
            val_d = at_last ? RST_VAL : inc[WIDTH-1:0];
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            val_q <= RST_VAL;
        else
            val_q <= val_d;
    end

    assign val_o  = val_q;
    assign wrap_o = step_i && !load_i && at_last;

endmodule

// File: rtl/bcd_cal_hour.sv
// Module: hours counter with run-time 12/24-hour format.
// Byte layout: bit 7 = 12-hour format, bit 5 = PM (12-hour only),
// BCD hour in bits 4:0 (12-hour) or bits 5:0 (24-hour).
// wrap_o marks the step into a new day (23->00 or 11 PM->12 AM).
// Assumes software loads a valid hour for the chosen format.
module bcd_cal_hour #(
    parameter int HW = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] load_val_i,
    input  logic       step_i,
    output logic [7:0] hour_o,
    output logic       wrap_o
);
    import bcd_cal_pkg::*;

    localparam logic [HW-1:0] H_ZERO   = '0;
    localparam logic [HW-1:0] H_ONE    = HW'(8'h01);
    localparam logic [HW-1:0] H_TWELVE = HW'(8'h12);

    logic          mode12_q, mode12_d;
    logic          pm_q, pm_d;
    logic [HW-1:0] hval_q, hval_d;
    logic [7:0]    ext;
    logic [7:0]    inc;
    logic          day_end;

    // Successor of the current hour digits and the day-boundary condition.
    always_comb begin
        ext            = '0;
        ext[HW-1:0]    = hval_q;
        inc            = bcd_inc(ext);
        day_end        = mode12_q ? (pm_q && ext == 8'h11) : (ext >= 8'h23);
    end

    // Next-state selection for format, PM flag and hour digits.
    always_comb begin
        mode12_d = mode12_q;
        pm_d     = pm_q;
        hval_d   = hval_q;
        if (load_i) begin
            mode12_d = load_val_i[7];
            if (load_val_i[7]) begin
                pm_d   = load_val_i[5];
                hval_d = {1'b0, load_val_i[4:0]};
            end else begin
                pm_d   = 1'b0;
                hval_d = load_val_i[HW-1:0];
            end
        end else if (step_i) begin
            if (mode12_q) begin
                if (ext >= 8'h12) begin
                    hval_d = H_ONE;
                end else if (ext == 8'h11) begin
                    hval_d = H_TWELVE;
                    pm_d   = !pm_q;
                end else begin
                    hval_d = inc[HW-1:0];
                end
            end else begin
                hval_d = day_end ? H_ZERO : inc[HW-1:0];
            end
        end
    end

    // State registers with synchronous active-low reset (24-hour, 00).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode12_q <= 1'b0;
            pm_q     <= 1'b0;
            hval_q   <= H_ZERO;
        end else begin
            mode12_q <= mode12_d;
            pm_q     <= pm_d;
            hval_q   <= hval_d;
        end
    end

    // Pack the visible hours byte.
    always_comb begin
        hour_o = '0;
        hour_o[7] = mode12_q;
        if (mode12_q) begin
            hour_o[5]   = pm_q;
            hour_o[4:0] = hval_q[4:0];
        end else begin
            hour_o[HW-1:0] = hval_q;
        end
    end

    assign wrap_o = step_i && !load_i && day_end;

endmodule

// File: rtl/bcd_cal_day.sv
// Module: day-of-month and month counters with month-length and
// leap-year handling. wrap_o marks the step from the last day of
// December into a new year. A date at or above the month's last day
// rolls over on the next step. Assumes leap_i comes from the year field.
module bcd_cal_day #(
    parameter int DW = 6,
    parameter int MW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          leap_i,
    input  logic          date_ld_i,
    input  logic          month_ld_i,
    input  logic [7:0]    ld_val_i,
    input  logic          step_i,
    output logic [DW-1:0] date_o,
    output logic [MW-1:0] month_o,
    output logic          wrap_o
);
    import bcd_cal_pkg::*;

    localparam logic [DW-1:0] D_ONE = DW'(8'h01);
    localparam logic [MW-1:0] M_ONE = MW'(8'h01);

    logic [DW-1:0] date_q, date_d;
    logic [MW-1:0] month_q, month_d;
    logic [7:0]    date_ext, month_ext;
    logic [7:0]    last_day;
    logic [7:0]    date_inc, month_inc;
    logic          month_end, year_end;

    // Month length, successors and boundary conditions.
    always_comb begin
        date_ext            = '0;
        date_ext[DW-1:0]    = date_q;
        month_ext           = '0;
        month_ext[MW-1:0]   = month_q;
        last_day            = month_last(month_ext, leap_i);
        date_inc            = bcd_inc(date_ext);
        month_inc           = bcd_inc(month_ext);
        month_end           = (date_ext >= last_day);
        year_end            = month_end && (month_ext >= 8'h12);
    end

    // Next-state selection: loads take priority over stepping.
    always_comb begin
        date_d  = date_q;
        month_d = month_q;
        if (date_ld_i || month_ld_i) begin
            if (date_ld_i)
                date_d = ld_val_i[DW-1:0];
            if (month_ld_i)
                month_d = ld_val_i[MW-1:0];
        end else if (step_i) begin
            if (month_end) begin
                date_d  = D_ONE;
                month_d = year_end ? M_ONE : month_inc[MW-1:0];
            end else begin
                date_d  = date_inc[DW-1:0];
            end
        end
    end

    // State registers with synchronous active-low reset (01 January).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            date_q  <= D_ONE;
            month_q <= M_ONE;
        end else begin
            date_q  <= date_d;
            month_q <= month_d;
        end
    end

    assign date_o  = date_q;
    assign month_o = month_q;
    assign wrap_o  = step_i && !date_ld_i && !month_ld_i && year_end;

endmodule

// File: rtl/bcd_cal_clock.sv
// Module: top of the BCD calendar clock. Chains tenths -> seconds ->
// minutes -> hours -> date/day-of-week -> month -> year on a one-cycle
// 10 Hz tick. Reset stands for a total power loss: counting stays
// blocked until any field write. Every write zeroes the tenths digit
// and suppresses the tick in that cycle. Assumes tick_i is a one-cycle
// pulse synchronous to clk.
module bcd_cal_clock #(
    parameter int SEC_W   = 7,
    parameter int HOUR_HW = 6,
    parameter int DATE_W  = 6,
    parameter int MONTH_W = 5,
    parameter int DOW_W   = 3,
    parameter int TEN_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               wr_en_i,
    input  logic [2:0]         wr_sel_i,
    input  logic [7:0]         wr_data_i,
    output logic [TEN_W-1:0]   tenths_o,
    output logic [SEC_W-1:0]   sec_o,
    output logic [SEC_W-1:0]   min_o,
    output logic [7:0]         hour_o,
    output logic [DOW_W-1:0]   dow_o,
    output logic [DATE_W-1:0]  date_o,
    output logic [MONTH_W-1:0] month_o,
    output logic [7:0]         year_o,
    output logic               halted_o
);
    import bcd_cal_pkg::*;

    localparam int NFLD = 8;

    logic            halted_q;
    logic            run;
    logic [NFLD-1:0] ld;
    logic            c_ten, c_sec, c_min, c_hour, c_day, c_year, c_dow;
    logic            leap;

    // One-hot field load strobes decoded from the select.
    genvar g;
    generate
        for (g = 0; g < NFLD; g++) begin : g_sel
            assign ld[g] = wr_en_i && (wr_sel_i == 3'(g));
        end
    endgenerate

    // Halt flag: set by power-loss reset, cleared by any write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halted_q <= 1'b1;
        else if (wr_en_i)
            halted_q <= 1'b0;
    end

    assign run      = tick_i && !halted_q && !wr_en_i;
    assign halted_o = halted_q;
    assign leap     = is_leap(year_o);

    bcd_cal_wrap #(.WIDTH(TEN_W), .FIRST(8'h00), .LAST(8'h09)) u_tenths (
        .clk(clk), .rst_n(rst_n), .load_i(wr_en_i), .load_val_i('0),
        .step_i(run), .val_o(tenths_o), .wrap_o(c_ten));

    bcd_cal_wrap #(.WIDTH(SEC_W), .FIRST(8'h00), .LAST(8'h59)) u_sec (
        .clk(clk), .rst_n(rst_n), .load_i(ld[FLD_SEC]),
        .load_val_i(wr_data_i[SEC_W-1:0]),
        .step_i(c_ten), .val_o(sec_o), .wrap_o(c_sec));

    bcd_cal_wrap #(.WIDTH(SEC_W), .FIRST(8'h00), .LAST(8'h59)) u_min (
        .clk(clk), .rst_n(rst_n), .load_i(ld[FLD_MIN]),
        .load_val_i(wr_data_i[SEC_W-1:0]),
        .step_i(c_sec), .val_o(min_o), .wrap_o(c_min));

    bcd_cal_hour #(.HW(HOUR_HW)) u_hour (
        .clk(clk), .rst_n(rst_n), .load_i(ld[FLD_HOUR]),
        .load_val_i(wr_data_i), .step_i(c_min),
        .hour_o(hour_o), .wrap_o(c_hour));

    bcd_cal_wrap #(.WIDTH(DOW_W), .FIRST(8'h00), .LAST(8'h06)) u_dow (
        .clk(clk), .rst_n(rst_n), .load_i(ld[FLD_DOW]),
        .load_val_i(wr_data_i[DOW_W-1:0]),
        .step_i(c_hour), .val_o(dow_o), .wrap_o(c_dow));

    bcd_cal_day #(.DW(DATE_W), .MW(MONTH_W)) u_day (
        .clk(clk), .rst_n(rst_n), .leap_i(leap),
        .date_ld_i(ld[FLD_DATE]), .month_ld_i(ld[FLD_MONTH]),
        .ld_val_i(wr_data_i), .step_i(c_hour),
        .date_o(date_o), .month_o(month_o), .wrap_o(c_day));

    bcd_cal_wrap #(.WIDTH(8), .FIRST(8'h00), .LAST(8'h99)) u_year (
        .clk(clk), .rst_n(rst_n), .load_i(ld[FLD_YEAR]),
        .load_val_i(wr_data_i),
        .step_i(c_day), .val_o(year_o), .wrap_o(c_year));

endmodule

// File: rtl/bcd_cal_clock_chk.sv
// Module: property checker for bcd_cal_clock, attached by bind.
// Observes ports only; assumes synchronous active-low reset.
module bcd_cal_clock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       wr_en_i,
    input logic [2:0] wr_sel_i,
    input logic [7:0] wr_data_i,
    input logic [3:0] tenths_o,
    input logic [6:0] sec_o,
    input logic [6:0] min_o,
    input logic [7:0] hour_o,
    input logic [2:0] dow_o,
    input logic [5:0] date_o,
    input logic [4:0] month_o,
    input logic [7:0] year_o,
    input logic       halted_o
);

    assert_halt_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && !wr_en_i) |=> (halted_o && $stable(tenths_o) && $stable(sec_o)));

    assert_write_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (!halted_o && tenths_o == 4'd0));

    assert_tenths_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !halted_o && !wr_en_i) |=>
        (tenths_o == (($past(tenths_o) == 4'd9) ? 4'd0 : $past(tenths_o) + 4'd1)));

    assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
                                   && $stable(date_o) && $stable(month_o) && $stable(year_o)));

    assert_format_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> (hour_o[7] == $past(hour_o[7])));

    assert_dow_with_date_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(date_o) == $stable(dow_o)));

    assert_sec_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 3'd0) |=> (sec_o == $past(wr_data_i[6:0])));

endmodule

bind bcd_cal_clock bcd_cal_clock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .tenths_o(tenths_o),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o), .halted_o(halted_o));

// File: tb/bcd_cal_clock_tb.sv
module bcd_cal_clock_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_sel_i = 3'd0;
    logic [7:0] wr_data_i = 8'h00;
    logic [3:0] tenths_o;
    logic [6:0] sec_o, min_o;
    logic [7:0] hour_o;
    logic [2:0] dow_o;
    logic [5:0] date_o;
    logic [4:0] month_o;
    logic [7:0] year_o;
    logic       halted_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    bcd_cal_clock u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .tenths_o(tenths_o),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o), .halted_o(halted_o));

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    // Load a moment one tenth-carry before a roll, then send ten ticks.
    task automatic roll(input logic [7:0] h, input logic [7:0] dw, input logic [7:0] d,
                        input logic [7:0] m, input logic [7:0] y);
        wr(3'd2, h); wr(3'd3, dw); wr(3'd6, y); wr(3'd5, m); wr(3'd4, d);
        wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        ticks(10);
    endtask

    task automatic t_reset;
        chk("R1", "tenths", tenths_o, 0);  chk("R1", "sec", sec_o, 0);
        chk("R1", "min", min_o, 0);        chk("R1", "hour", hour_o, 0);
        chk("R1", "dow", dow_o, 0);        chk("R1", "date", date_o, 1);
        chk("R1", "month", month_o, 1);    chk("R1", "year", year_o, 0);
        chk("R1", "halted", halted_o, 1);
    endtask

    task automatic t_halt;
        ticks(25);
        chk("R2", "tenths halted", tenths_o, 0);
        chk("R2", "sec halted", sec_o, 0);
        chk("R2", "still halted", halted_o, 1);
    endtask

    task automatic t_release;
        wr(3'd7, 8'hFF);
        chk("R3", "halt cleared by select 7", halted_o, 0);
        chk("R12", "select 7 leaves sec", sec_o, 0);
        chk("R12", "select 7 leaves hour", hour_o, 0);
        ticks(3);
        chk("R4", "tenths after 3", tenths_o, 3);
        wr(3'd1, 8'h42);
        chk("R3", "write zeroes tenths", tenths_o, 0);
        chk("R12", "min loaded", min_o, 'h42);
        chk("R12", "sec untouched", sec_o, 0);
        ticks(4);
        // write and tick in the same cycle: write wins
        @(negedge clk);
        tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 3'd0; wr_data_i = 8'h17;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        chk("R3", "tick dropped on write", tenths_o, 0);
        chk("R12", "sec loaded", sec_o, 'h17);
        repeat (5) @(negedge clk);
        chk("R5", "idle holds sec", sec_o, 'h17);
    endtask

    task automatic t_tenths;
        wr(3'd0, 8'h09);
        ticks(9);
        chk("R4", "tenths at 9", tenths_o, 9);
        chk("R4", "sec before carry", sec_o, 'h09);
        ticks(1);
        chk("R4", "tenths wrap", tenths_o, 0);
        chk("R5", "sec BCD 09->10", sec_o, 'h10);
    endtask

    task automatic t_24h;
        roll(8'h23, 8'h02, 8'h15, 8'h03, 8'h21);
        chk("R5", "sec wrap", sec_o, 0);
        chk("R5", "min wrap", min_o, 0);
        chk("R6", "hour 23->00", hour_o, 0);
        chk("R6", "date advance", date_o, 'h16);
        chk("R11", "dow advance", dow_o, 3);
        roll(8'h09, 8'h03, 8'h16, 8'h03, 8'h21);
        chk("R6", "hour 09->10", hour_o, 'h10);
        chk("R11", "dow held", dow_o, 3);
        chk("R6", "date held", date_o, 'h16);
    endtask

    task automatic t_12h;
        roll(8'h91, 8'h01, 8'h10, 8'h06, 8'h21);
        chk("R7", "11 AM -> 12 PM", hour_o, 'hB2);
        chk("R7", "no date at noon", date_o, 'h10);
        roll(8'hB2, 8'h01, 8'h10, 8'h06, 8'h21);
        chk("R7", "12 PM -> 1 PM", hour_o, 'hA1);
        roll(8'hB1, 8'h01, 8'h10, 8'h06, 8'h21);
        chk("R7", "11 PM -> 12 AM", hour_o, 'h92);
        chk("R7", "date at midnight", date_o, 'h11);
        chk("R11", "dow at midnight", dow_o, 2);
        wr(3'd2, 8'h05);
        chk("R7", "back to 24h", hour_o, 'h05);
    endtask

    task automatic t_months;
        roll(8'h23, 8'h00, 8'h30, 8'h04, 8'h21);
        chk("R8", "Apr 30 -> month", month_o, 'h05);
        chk("R8", "Apr 30 -> date", date_o, 'h01);
        roll(8'h23, 8'h00, 8'h30, 8'h01, 8'h21);
        chk("R8", "Jan 30 -> 31", date_o, 'h31);
        roll(8'h23, 8'h00, 8'h31, 8'h01, 8'h21);
        chk("R8", "Jan 31 -> Feb", month_o, 'h02);
        roll(8'h23, 8'h00, 8'h30, 8'h11, 8'h21);
        chk("R8", "Nov 30 -> Dec", month_o, 'h12);
    endtask

    task automatic t_feb;
        roll(8'h23, 8'h00, 8'h28, 8'h02, 8'h23);
        chk("R9", "yr23 Feb28 -> Mar", month_o, 'h03);
        roll(8'h23, 8'h00, 8'h28, 8'h02, 8'h24);
        chk("R9", "yr24 Feb28 -> 29", date_o, 'h29);
        roll(8'h23, 8'h00, 8'h29, 8'h02, 8'h24);
        chk("R9", "yr24 Feb29 -> Mar", month_o, 'h03);
        roll(8'h23, 8'h00, 8'h28, 8'h02, 8'h00);
        chk("R9", "yr00 Feb28 -> 29", date_o, 'h29);
        roll(8'h23, 8'h00, 8'h28, 8'h02, 8'h10);
        chk("R9", "yr10 Feb28 -> Mar", month_o, 'h03);
        roll(8'h23, 8'h00, 8'h28, 8'h02, 8'h12);
        chk("R9", "yr12 Feb28 -> 29", date_o, 'h29);
    endtask

    task automatic t_year;
        roll(8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
        chk("R10", "year 99 -> 00", year_o, 'h00);
        chk("R10", "month Jan", month_o, 'h01);
        chk("R10", "date 01", date_o, 'h01);
        chk("R11", "dow 6 -> 0", dow_o, 0);
        roll(8'h23, 8'h04, 8'h31, 8'h12, 8'h19);
        chk("R10", "year 19 -> 20", year_o, 'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_halt;
        t_release;
        t_tenths;
        t_24h;
        t_12h;
        t_months;
        t_feb;
        t_year;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule